// File: doc/BRIEF.md
# Trap Entry Sequencer

This block applies, in a single clock, the architectural state changes a processor makes when it enters a trap. It takes in the following:

- a trap request, marked as synchronous (caused by the faulting instruction) or asynchronous (an external event);
- a separate reset request;
- the 8-bit trap type;
- the program counter and next program counter of the instruction in execute;
- the enable-traps and supervisor bits of the status word;
- the current window pointer;
- the base field of the trap base register.

It does not copy the status word. It makes only changes that can be undone:

- traps are disabled;
- the old supervisor bit moves into the previous-supervisor bit and supervisor is set;
- the window pointer steps down by one, wrapping around the window count.

The return pair is written into locals 1 and 2 of the new window through two write ports. The trap type is stored in the trap base register, and the vector is loaded into PC and nPC. A reset uses the fixed vectors 0 and 4.

An asynchronous request that arrives while traps are disabled is dropped. A synchronous request that arrives while traps are disabled sends the block into a sticky error mode, and the trap is not taken.

Top module: `trap_entry_seq`

## Requirements
- R1: An accepted request gives a one-cycle `taken_o` strobe on the clock after the request is sampled, and `et_out` is 0 in that cycle.
- R2: On entry, `ps_out` takes the sampled supervisor bit and `s_out` becomes 1.
- R3: On entry, `cwp_out` is the sampled pointer minus one, and pointer 0 wraps to NWIN-1 (7 by default).
- R4: On entry, `wr_en` pulses with `wr_win` equal to the new window pointer, and `wr_l1_data` and `wr_l2_data` carry the saved return pair.
- R5: A synchronous trap or a reset saves (PC, nPC). An asynchronous trap saves (nPC, nPC+4) modulo 2^AW, which skips the instruction that completes.
- R6: `tbr_out` is {base, trap type, 4'b0000}: base in bits 31:12 and type in bits 11:4. A non-reset trap loads PC with that value and nPC with that value plus 4.
- R7: A reset request is taken even when traps are disabled, loads PC = 0 and nPC = 4, and clears error mode.
- R8: An asynchronous request with enable-traps = 0 is ignored: there is no strobe and all outputs keep their values.
- R9: A synchronous request with enable-traps = 0 sets `err_out`, which holds until reset. No trap is taken, and every non-reset request is ignored while `err_out` is 1.
- R10: `kill_cur` pulses together with the strobe for synchronous traps only.
- R11: After `rst_n` reset: no strobe, `wr_en` 0, `err_out` 0, `et_out` 0, `s_out` 1, `ps_out` 0, `cwp_out` 0, `tbr_out` 0, PC 0, nPC 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap request |
| trap_sync | input | 1 | 1 = synchronous trap, 0 = asynchronous |
| reset_req | input | 1 | Reset trap request |
| trap_type | input | 8 | Trap type code |
| pc_in | input | AW | PC of the instruction in execute |
| npc_in | input | AW | nPC of the instruction in execute |
| psr_et_in | input | 1 | Current enable-traps bit |
| psr_s_in | input | 1 | Current supervisor bit |
| cwp_in | input | CWPW | Current window pointer |
| tbr_base_in | input | AW-12 | Trap base field |
| taken_o | output | 1 | One-cycle trap-taken strobe |
| kill_cur | output | 1 | Abort the faulting instruction (synchronous) |
| err_out | output | 1 | Error mode |
| et_out | output | 1 | Updated enable-traps bit |
| s_out | output | 1 | Updated supervisor bit |
| ps_out | output | 1 | Updated previous-supervisor bit |
| cwp_out | output | CWPW | Updated window pointer |
| wr_en | output | 1 | Register write strobe for both save ports |
| wr_win | output | CWPW | Window written |
| wr_l1_data | output | AW | Saved return PC for local 1 |
| wr_l2_data | output | AW | Saved return nPC for local 2 |
| tbr_out | output | AW | Trap base register |
| pc_out | output | AW | New PC |
| npc_out | output | AW | New nPC |

## Verification
Every result of an entry is held in one register stage. A request sampled at a rising edge therefore shows all of its effects after that same edge: the strobe, status bits, pointer, write port, trap base, vectors and error flag. The bench drives inputs on the falling edge and reads results on the next falling edge, one edge later, so every check lands in the cycle of the strobe. For the ignored cases, the bench compares the held outputs in that same cycle with their values from before the request.

// File: rtl/trap_entry_seq.sv
module trap_entry_seq #(
  parameter int NWIN = 8,
  parameter int AW   = 32,
  localparam int CWPW  = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int BASEW = AW - 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_req,
  input  logic             trap_sync,
  input  logic             reset_req,
  input  logic [7:0]       trap_type,
  input  logic [AW-1:0]    pc_in,
  input  logic [AW-1:0]    npc_in,
  input  logic             psr_et_in,
  input  logic             psr_s_in,
  input  logic [CWPW-1:0]  cwp_in,
  input  logic [BASEW-1:0] tbr_base_in,
  output logic             taken_o,
  output logic             kill_cur,
  output logic             err_out,
  output logic             et_out,
  output logic             s_out,
  output logic             ps_out,
  output logic [CWPW-1:0]  cwp_out,
  output logic             wr_en,
  output logic [CWPW-1:0]  wr_win,
  output logic [AW-1:0]    wr_l1_data,
  output logic [AW-1:0]    wr_l2_data,
  output logic [AW-1:0]    tbr_out,
  output logic [AW-1:0]    pc_out,
  output logic [AW-1:0]    npc_out
);

  localparam logic [AW-1:0]   STEP     = AW'(4);
  localparam logic [CWPW-1:0] TOP_WIN  = CWPW'(NWIN - 1);

  logic            take_trap, take_rst, take, enter_err;
  logic            save_cur;
  logic [CWPW-1:0] cwp_next;
  logic [AW-1:0]   vec, ret_a, ret_b;

  assign take_rst  = reset_req;
  assign take_trap = trap_req & psr_et_in & ~err_out & ~reset_req;
  assign enter_err = trap_req & trap_sync & ~psr_et_in & ~err_out & ~reset_req;
  assign take      = take_rst | take_trap;

  assign cwp_next  = (cwp_in == '0) ? TOP_WIN : cwp_in - 1'b1;
  assign vec       = {tbr_base_in, trap_type, 4'b0000};

  assign save_cur  = trap_sync | reset_req;
  assign ret_a     = save_cur ? pc_in  : npc_in;
  assign ret_b     = save_cur ? npc_in : npc_in + STEP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken_o    <= 1'b0;
      kill_cur   <= 1'b0;
      err_out    <= 1'b0;
      et_out     <= 1'b0;
      s_out      <= 1'b1;
      ps_out     <= 1'b0;
      cwp_out    <= '0;
      wr_en      <= 1'b0;
      wr_win     <= '0;
      wr_l1_data <= '0;
      wr_l2_data <= '0;
      tbr_out    <= '0;
      pc_out     <= '0;
      npc_out    <= STEP;
    end else begin
      taken_o  <= take;
      wr_en    <= take;
      kill_cur <= take_trap & trap_sync;
      if (take_rst)       err_out <= 1'b0;
      else if (enter_err) err_out <= 1'b1;
      if (take) begin
        et_out     <= 1'b0;
        s_out      <= 1'b1;
        ps_out     <= psr_s_in;
        cwp_out    <= cwp_next;
        wr_win     <= cwp_next;
        wr_l1_data <= ret_a;
        wr_l2_data <= ret_b;
        tbr_out    <= vec;
        pc_out     <= take_rst ? '0   : vec;
        npc_out    <= take_rst ? STEP : vec + STEP;
      end
    end
  end

endmodule

module trap_entry_seq_chk #(
  parameter int NWIN = 8,
  parameter int AW   = 32,
  localparam int CWPW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_req,
  input logic            trap_sync,
  input logic            reset_req,
  input logic            psr_et_in,
  input logic            psr_s_in,
  input logic [CWPW-1:0] cwp_in,
  input logic            taken_o,
  input logic            kill_cur,
  input logic            err_out,
  input logic            et_out,
  input logic            s_out,
  input logic            ps_out,
  input logic [CWPW-1:0] cwp_out,
  input logic [AW-1:0]   pc_out,
  input logic [AW-1:0]   npc_out
);

  // R1
  et_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> !et_out);

  // R2
  ps_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> (ps_out == $past(psr_s_in)) && s_out);

  // R3
  cwp_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> int'(cwp_out) ==
      (($past(cwp_in) == '0) ? NWIN - 1 : int'($past(cwp_in)) - 1));

  // R7
  reset_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reset_req) |-> taken_o && (pc_out == '0) && (npc_out == AW'(4)) && !err_out);

  // R8
  async_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(trap_req && !trap_sync && !psr_et_in && !reset_req) |-> !taken_o);

  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(trap_req && trap_sync && !psr_et_in && !reset_req) |-> err_out && !taken_o);

  // R10
  kill_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill_cur |-> taken_o && $past(trap_sync) && !$past(reset_req));

endmodule

bind trap_entry_seq trap_entry_seq_chk #(.NWIN(NWIN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_sync(trap_sync),
  .reset_req(reset_req), .psr_et_in(psr_et_in), .psr_s_in(psr_s_in),
  .cwp_in(cwp_in), .taken_o(taken_o), .kill_cur(kill_cur), .err_out(err_out),
  .et_out(et_out), .s_out(s_out), .ps_out(ps_out), .cwp_out(cwp_out),
  .pc_out(pc_out), .npc_out(npc_out)
);

// File: tb/test_trap_entry_seq.sv
module test_trap_entry_seq;

  localparam int NWIN = 8;
  localparam int AW   = 32;
  localparam int NV   = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trap_req = 0, trap_sync = 0, reset_req = 0, psr_et_in = 0, psr_s_in = 0;
  logic [7:0]  trap_type = '0;
  logic [31:0] pc_in = '0, npc_in = '0;
  logic [2:0]  cwp_in = '0;
  logic [19:0] tbr_base_in = '0;
  logic taken_o, kill_cur, err_out, et_out, s_out, ps_out, wr_en;
  logic [2:0]  cwp_out, wr_win;
  logic [31:0] wr_l1_data, wr_l2_data, tbr_out, pc_out, npc_out;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trap_entry_seq #(.NWIN(NWIN), .AW(AW)) i_trap_entry_seq (.*);

  // {sync, s, cwp[2:0], type[7:0], base[19:0], pc[31:0], npc[31:0]}
  localparam logic [96:0] TBL [NV] = '{
    {1'b1, 1'b1, 3'd3, 8'h05, 20'hABCDE, 32'h0000_1000, 32'h0000_1004},
    {1'b0, 1'b0, 3'd0, 8'h11, 20'h00001, 32'h0000_2000, 32'h0000_2004},
    {1'b0, 1'b1, 3'd7, 8'h1F, 20'hFFFFF, 32'h0000_3008, 32'h0000_4000},
    {1'b1, 1'b0, 3'd1, 8'h80, 20'h12345, 32'hFFFF_FFF8, 32'hFFFF_FFFC},
    {1'b0, 1'b0, 3'd5, 8'hFF, 20'h80000, 32'h0000_0010, 32'hFFFF_FFFC}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic req, input logic sy, input logic rr, input logic et,
                       input logic s, input logic [2:0] cw, input logic [7:0] tt,
                       input logic [19:0] b, input logic [31:0] p, input logic [31:0] np);
    @(negedge clk);
    trap_req = req; trap_sync = sy; reset_req = rr; psr_et_in = et; psr_s_in = s;
    cwp_in = cw; trap_type = tt; tbr_base_in = b; pc_in = p; npc_in = np;
    @(negedge clk);
    trap_req = 0; reset_req = 0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 taken", 32'(taken_o), 0);
    chk("R11 wr_en", 32'(wr_en), 0);
    chk("R11 err", 32'(err_out), 0);
    chk("R11 et", 32'(et_out), 0);
    chk("R11 s/ps", {30'b0, s_out, ps_out}, 32'h2);
    chk("R11 cwp", 32'(cwp_out), 0);
    chk("R11 tbr", tbr_out, 0);
    chk("R11 pc", pc_out, 0);
    chk("R11 npc", npc_out, 4);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic sy, s;
      logic [2:0] cw, ecw;
      logic [7:0] tt;
      logic [19:0] b;
      logic [31:0] p, np, ev;
      {sy, s, cw, tt, b, p, np} = TBL[i];
      ecw = (cw == 3'd0) ? 3'd7 : cw - 3'd1;
      ev  = {b, tt, 4'b0000};
      drive(1, sy, 0, 1, s, cw, tt, b, p, np);
      chk("R1 taken", 32'(taken_o), 1);
      chk("R1 et cleared", 32'(et_out), 0);
      chk("R2 ps", 32'(ps_out), 32'(s));
      chk("R2 s set", 32'(s_out), 1);
      chk("R3 cwp", 32'(cwp_out), 32'(ecw));
      chk("R4 wr_en", 32'(wr_en), 1);
      chk("R4 wr_win", 32'(wr_win), 32'(ecw));
      chk("R5 local1", wr_l1_data, sy ? p : np);
      chk("R5 local2", wr_l2_data, sy ? np : np + 32'd4);
      chk("R6 tbr", tbr_out, ev);
      chk("R6 pc", pc_out, ev);
      chk("R6 npc", npc_out, ev + 32'd4);
      chk("R10 kill", 32'(kill_cur), 32'(sy));
      @(negedge clk);
      chk("R1 strobe one cycle", 32'(taken_o), 0);
    end

    // R8: async with traps disabled ignored
    drive(1, 0, 0, 0, 1, 3'd4, 8'h22, 20'h55555, 32'h9000, 32'h9004);
    chk("R8 no strobe", 32'(taken_o), 0);
    chk("R8 pc held", pc_out, 32'h8000_0FF0);
    chk("R8 cwp held", 32'(cwp_out), 3'd4);
    chk("R8 no err", 32'(err_out), 0);

    // R7: reset with traps disabled
    drive(0, 0, 1, 0, 0, 3'd0, 8'h00, 20'h55555, 32'hA000, 32'hA004);
    chk("R7 taken", 32'(taken_o), 1);
    chk("R7 pc", pc_out, 0);
    chk("R7 npc", npc_out, 4);
    chk("R7 cwp wrap", 32'(cwp_out), 7);
    chk("R10 no kill on reset", 32'(kill_cur), 0);

    // R9: sync with traps disabled -> error mode
    drive(1, 1, 0, 0, 1, 3'd2, 8'h09, 20'h11111, 32'hB000, 32'hB004);
    chk("R9 err set", 32'(err_out), 1);
    chk("R9 no strobe", 32'(taken_o), 0);
    chk("R9 pc held", pc_out, 0);
    drive(1, 0, 0, 1, 1, 3'd2, 8'h09, 20'h11111, 32'hB000, 32'hB004);
    chk("R9 ignored in error", 32'(taken_o), 0);
    chk("R9 err sticky", 32'(err_out), 1);
    chk("R9 cwp held", 32'(cwp_out), 7);
    drive(0, 0, 1, 0, 1, 3'd6, 8'h00, 20'h0, 32'hC000, 32'hC004);
    chk("R7 err cleared", 32'(err_out), 0);
    chk("R7 taken from error", 32'(taken_o), 1);
    chk("R5 reset saves pc", wr_l1_data, 32'hC000);
    chk("R5 reset saves npc", wr_l2_data, 32'hC004);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule